// File: doc/BRIEF.md
# Flash Ring Log Write Controller

This block appends fixed-size records to a flash array that it handles as one circular sequence of entries. Each sector holds a whole number of entries, so no record ever straddles an erase unit. The host raises a write request with a data word. The controller programs that word into the entry at its write pointer and then moves the pointer forward by one entry, wrapping from the last entry back to the first.

Whenever the pointer steps onto the first entry of a sector, the controller erases that whole sector before it accepts the next request. This keeps at least one blank entry ahead of the pointer at all times. Because of that blank entry, the pointer can be rebuilt after power-up. The controller reads the first word of every entry in turn and restarts just after the newest record. If no entry at all is blank, it erases sector 0 and starts there.

The flash side is a one-cycle command strobe with an entry index and a data word, plus a busy flag and a read-data-valid flag. The log payload format and host readout are outside this block.

Top module: `flash_ring_logger`

## Requirements
- R1: While reset is held and during the power-up scan, wrReady stays low. After reset the controller issues one read command for each entry, in increasing index order 0 to NUM_ENTRIES-1, and waits for flashRdValid before issuing the next read.
- R2: An entry counts as blank only when its first word reads as all ones. Any other value, including a single zero bit, marks it as used.
- R3: After the scan, the write pointer is the lowest-index blank entry whose predecessor in ring order is used. Entry 0's predecessor is entry NUM_ENTRIES-1. The first program after boot goes to that entry.
- R4: When every entry is blank, the write pointer starts at entry 0.
- R5: When no entry is blank, the controller erases sector 0 (erase command with entry address 0) before raising wrReady, and the pointer starts at entry 0.
- R6: A request is accepted on a clock edge where wrReq and wrReady are both high. In the next cycle, a program command appears with flashAddr equal to the pointer and flashWrData equal to the accepted wrData. The pointer then advances by one entry.
- R7: When the advanced pointer is the first entry of a sector, an erase command with that entry's index is issued as the very next command, before wrReady rises again.
- R8: After a program to entry NUM_ENTRIES-1, the pointer wraps to entry 0, which triggers the erase of sector 0.
- R9: wrReady is low whenever flashBusy is high, and from the cycle after an accept until the program (and any erase) has finished. No command is issued while flashBusy is high.
- R10: flashCmd encodes 0 for none, 1 for read, 2 for program and 3 for erase. A program or erase strobe lasts exactly one cycle. The flash raises busy in the cycle after a program or erase and answers a read with flashRdValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; starts the power-up scan when released |
| wrReq | input | 1 | Host write request |
| wrData | input | DATA_W | Word to store in the entry |
| wrReady | output | 1 | Controller can accept a request this cycle |
| flashCmd | output | 2 | Command strobe: 0 none, 1 read, 2 program, 3 erase |
| flashAddr | output | ENTRY_W | Entry index; for erase, the first entry of the sector |
| flashWrData | output | DATA_W | Word to program |
| flashRdData | input | DATA_W | First word of the entry that was read |
| flashRdValid | input | 1 | flashRdData is valid this cycle |
| flashBusy | input | 1 | Flash is executing a program or erase |

## Verification
A wrong scan result, such as a bad blank-entry test or a bad ring-predecessor choice, shows up at the first program after boot, whose address lands on the wrong entry. A pointer that drifts or fails to wrap produces a program address that breaks the +1 sequence on the very next write. A missed boundary shows as a program, or a raised wrReady, where an erase command of the new sector was due. Every command is compared in order against a predicted stream, so any of these faults is caught within one command of where it arises.

// File: rtl/flash_ring_pkg.sv
package flash_ring_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } flash_op_e;

  typedef struct packed {
    logic scanClr;
    logic scanEval;
    logic scanNext;
    logic ptrLoad;
    logic ptrInc;
    logic dataLoad;
    logic selScan;
    logic selErase;
  } dp_ctrl_t;

endpackage

// File: rtl/flash_ring_datapath.sv
module flash_ring_datapath
  import flash_ring_pkg::*;
#(
  parameter int NUM_SECTORS    = 4,
  parameter int SECTOR_ENTRIES = 4,
  parameter int DATA_W         = 32,
  localparam int NUM_ENTRIES   = NUM_SECTORS * SECTOR_ENTRIES,
  localparam int ENTRY_W       = $clog2(NUM_ENTRIES),
  localparam int OFF_W         = $clog2(SECTOR_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_ctrl_t           ctl,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  rdData,
  output logic [ENTRY_W-1:0] flashAddr,
  output logic [DATA_W-1:0]  flashWrData,
  output logic               scanLast,
  output logic               noneEmpty,
  output logic               atBoundary
);

  localparam logic [ENTRY_W-1:0] LAST_IDX = ENTRY_W'(NUM_ENTRIES - 1);

  logic [ENTRY_W-1:0] ptr;
  logic [ENTRY_W-1:0] scanIdx;
  logic [ENTRY_W-1:0] foundIdx;
  logic [ENTRY_W-1:0] eraseBase;
  logic [ENTRY_W-1:0] chosenPtr;
  logic [DATA_W-1:0]  dataReg;
  logic               prevUsed;
  logic               found;
  logic               anyEmpty;
  logic               entry0Empty;
  logic               isEmpty;

  assign isEmpty  = (rdData == {DATA_W{1'b1}});
  assign scanLast = (scanIdx == LAST_IDX);
  assign noneEmpty = !anyEmpty;

  // entry 0 wins when its ring predecessor (last entry) is used
  assign chosenPtr = (found && !(entry0Empty && prevUsed)) ? foundIdx : '0;

  generate
    if (OFF_W == 0) begin : g_single
      assign eraseBase  = ptr;
      assign atBoundary = 1'b1;
    end else begin : g_multi
      assign eraseBase  = {ptr[ENTRY_W-1:OFF_W], {OFF_W{1'b0}}};
      assign atBoundary = (ptr[OFF_W-1:0] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanIdx     <= '0;
      prevUsed    <= 1'b0;
      found       <= 1'b0;
      foundIdx    <= '0;
      anyEmpty    <= 1'b0;
      entry0Empty <= 1'b0;
    end else if (ctl.scanClr) begin
      scanIdx     <= '0;
      prevUsed    <= 1'b0;
      found       <= 1'b0;
      foundIdx    <= '0;
      anyEmpty    <= 1'b0;
      entry0Empty <= 1'b0;
    end else begin
      if (ctl.scanEval) begin
        if (scanIdx == '0) entry0Empty <= isEmpty;
        if (isEmpty) anyEmpty <= 1'b1;
        if (isEmpty && prevUsed && !found && scanIdx != '0) begin
          found    <= 1'b1;
          foundIdx <= scanIdx;
        end
        prevUsed <= !isEmpty;
      end
      if (ctl.scanNext) scanIdx <= scanIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      dataReg <= '0;
    end else begin
      if (ctl.dataLoad) dataReg <= wrData;
      if (ctl.ptrLoad)     ptr <= chosenPtr;
      else if (ctl.ptrInc) ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
    end
  end

  always_comb begin
    if (ctl.selScan)       flashAddr = scanIdx;
    else if (ctl.selErase) flashAddr = eraseBase;
    else                   flashAddr = ptr;
  end

  assign flashWrData = dataReg;

endmodule

// File: rtl/flash_ring_control.sv
module flash_ring_control
  import flash_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrReq,
  input  logic       flashBusy,
  input  logic       flashRdValid,
  input  logic       scanLast,
  input  logic       noneEmpty,
  input  logic       atBoundary,
  output dp_ctrl_t   ctl,
  output logic [1:0] flashCmd,
  output logic       wrReady
);

  typedef enum logic [3:0] {
    S_BOOT, S_SCAN_RD, S_SCAN_WAIT, S_LOAD, S_IDLE,
    S_PROG, S_PROG_WAIT, S_ERASE, S_ERASE_WAIT
  } state_e;

  state_e state, stateNext;
  flash_op_e op;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_BOOT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    op        = OP_NONE;
    wrReady   = 1'b0;
    case (state)
      S_BOOT: begin
        ctl.scanClr = 1'b1;
        stateNext   = S_SCAN_RD;
      end
      S_SCAN_RD: begin
        op          = OP_READ;
        ctl.selScan = 1'b1;
        stateNext   = S_SCAN_WAIT;
      end
      S_SCAN_WAIT: begin
        if (flashRdValid) begin
          ctl.scanEval = 1'b1;
          if (scanLast) stateNext = S_LOAD;
          else begin
            ctl.scanNext = 1'b1;
            stateNext    = S_SCAN_RD;
          end
        end
      end
      S_LOAD: begin
        ctl.ptrLoad = 1'b1;
        stateNext   = noneEmpty ? S_ERASE : S_IDLE;
      end
      S_IDLE: begin
        wrReady = !flashBusy;
        if (wrReq && !flashBusy) begin
          ctl.dataLoad = 1'b1;
          stateNext    = S_PROG;
        end
      end
      S_PROG: begin
        op         = OP_PROG;
        ctl.ptrInc = 1'b1;
        stateNext  = S_PROG_WAIT;
      end
      S_PROG_WAIT: begin
        if (!flashBusy) stateNext = atBoundary ? S_ERASE : S_IDLE;
      end
      S_ERASE: begin
        op           = OP_ERASE;
        ctl.selErase = 1'b1;
        stateNext    = S_ERASE_WAIT;
      end
      S_ERASE_WAIT: begin
        if (!flashBusy) stateNext = S_IDLE;
      end
      default: stateNext = S_BOOT;
    endcase
  end

  assign flashCmd = op;

endmodule

// File: rtl/flash_ring_logger.sv
module flash_ring_logger
  import flash_ring_pkg::*;
#(
  parameter int NUM_SECTORS    = 4,
  parameter int SECTOR_ENTRIES = 4,
  parameter int DATA_W         = 32,
  localparam int NUM_ENTRIES   = NUM_SECTORS * SECTOR_ENTRIES,
  localparam int ENTRY_W       = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrReq,
  input  logic [DATA_W-1:0]  wrData,
  output logic               wrReady,
  output logic [1:0]         flashCmd,
  output logic [ENTRY_W-1:0] flashAddr,
  output logic [DATA_W-1:0]  flashWrData,
  input  logic [DATA_W-1:0]  flashRdData,
  input  logic               flashRdValid,
  input  logic               flashBusy
);

  dp_ctrl_t ctl;
  logic     scanLast;
  logic     noneEmpty;
  logic     atBoundary;

  flash_ring_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrReq        (wrReq),
    .flashBusy    (flashBusy),
    .flashRdValid (flashRdValid),
    .scanLast     (scanLast),
    .noneEmpty    (noneEmpty),
    .atBoundary   (atBoundary),
    .ctl          (ctl),
    .flashCmd     (flashCmd),
    .wrReady      (wrReady)
  );

  flash_ring_datapath #(
    .NUM_SECTORS    (NUM_SECTORS),
    .SECTOR_ENTRIES (SECTOR_ENTRIES),
    .DATA_W         (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .wrData      (wrData),
    .rdData      (flashRdData),
    .flashAddr   (flashAddr),
    .flashWrData (flashWrData),
    .scanLast    (scanLast),
    .noneEmpty   (noneEmpty),
    .atBoundary  (atBoundary)
  );

endmodule

// File: rtl/flash_ring_checker.sv
module flash_ring_checker #(
  parameter int NUM_SECTORS    = 4,
  parameter int SECTOR_ENTRIES = 4,
  localparam int NUM_ENTRIES   = NUM_SECTORS * SECTOR_ENTRIES,
  localparam int ENTRY_W       = $clog2(NUM_ENTRIES)
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrReq,
  input logic               wrReady,
  input logic [1:0]         flashCmd,
  input logic [ENTRY_W-1:0] flashAddr,
  input logic               flashBusy
);

  localparam logic [ENTRY_W-1:0] LAST_IDX = ENTRY_W'(NUM_ENTRIES - 1);

  logic [ENTRY_W-1:0] nextAddr;
  logic [ENTRY_W-1:0] expProg;
  logic [ENTRY_W-1:0] expErase;
  logic               progSeen;
  logic               pendErase;
  logic               eraseAligned;

  assign nextAddr     = (flashAddr == LAST_IDX) ? '0 : flashAddr + 1'b1;
  assign eraseAligned = ((int'(flashAddr) % SECTOR_ENTRIES) == 0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progSeen  <= 1'b0;
      pendErase <= 1'b0;
      expProg   <= '0;
      expErase  <= '0;
    end else if (flashCmd == 2'd2) begin
      progSeen  <= 1'b1;
      expProg   <= nextAddr;
      expErase  <= nextAddr;
      pendErase <= ((int'(nextAddr) % SECTOR_ENTRIES) == 0);
    end else if (flashCmd == 2'd3) begin
      pendErase <= 1'b0;
    end
  end

  AST_CMD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmd != 2'd0) |-> !flashBusy);  // R9
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> !flashBusy);  // R9
  AST_ACCEPT_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (wrReady && wrReq) |=> (flashCmd == 2'd2));  // R6
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (wrReady && wrReq) |=> !wrReady);  // R9
  AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmd == 2'd3) |-> eraseAligned);  // R7
  AST_PROG_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmd == 2'd2 && progSeen) |-> (flashAddr == expProg));  // R8
  AST_ERASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmd != 2'd0 && pendErase) |-> (flashCmd == 2'd3 && flashAddr == expErase));  // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmd[1]) |=> (flashCmd == 2'd0));  // R10

endmodule

bind flash_ring_logger flash_ring_checker #(
  .NUM_SECTORS    (NUM_SECTORS),
  .SECTOR_ENTRIES (SECTOR_ENTRIES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrReq     (wrReq),
  .wrReady   (wrReady),
  .flashCmd  (flashCmd),
  .flashAddr (flashAddr),
  .flashBusy (flashBusy)
);

// File: tb/flash_ring_logger_test.sv
module flash_ring_logger_test;

  localparam int NS = 4;
  localparam int SE = 4;
  localparam int N  = NS * SE;
  localparam int DW = 32;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrReq = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          wrReady;
  logic [1:0]    flashCmd;
  logic [AW-1:0] flashAddr;
  logic [DW-1:0] flashWrData;
  logic [DW-1:0] flashRdData = '0;
  logic          flashRdValid = 1'b0;
  logic          flashBusy;

  int compared = 0;
  int mismatched = 0;
  int busyCnt = 0;
  int cycles = 0;
  logic [DW-1:0] mem [N];

  typedef struct {
    logic [1:0]    op;
    int            addr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  flash_ring_logger #(.NUM_SECTORS(NS), .SECTOR_ENTRIES(SE), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrData(wrData), .wrReady(wrReady),
    .flashCmd(flashCmd), .flashAddr(flashAddr), .flashWrData(flashWrData),
    .flashRdData(flashRdData), .flashRdValid(flashRdValid), .flashBusy(flashBusy)
  );

  // flash model: busy rises the cycle after program/erase, reads answer next cycle
  assign flashBusy = (busyCnt != 0);
  always @(posedge clk) begin
    flashRdValid <= 1'b0;
    if (busyCnt != 0) busyCnt <= busyCnt - 1;
    case (flashCmd)
      2'd1: begin flashRdData <= mem[flashAddr]; flashRdValid <= 1'b1; end
      2'd2: begin mem[flashAddr] <= flashWrData; busyCnt <= 3; end
      2'd3: begin
        for (int k = 0; k < SE; k++) mem[int'(flashAddr) + k] <= '1;
        busyCnt <= 6;
      end
      default: ;
    endcase
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: every command strobe is compared against the predicted stream
  always @(negedge clk) begin
    if (rstN && flashCmd != 2'd0) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected command op", int'(flashCmd), 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(flashCmd == e.op, e.tag, "command op", int'(flashCmd), int'(e.op));
        check(int'(flashAddr) == e.addr, e.tag, "command addr", int'(flashAddr), e.addr);
        if (e.op == 2'd2)
          check(flashWrData == e.data, e.tag, "program data", int'(flashWrData), int'(e.data));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      compared++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic push(input logic [1:0] op, input int addr, input logic [DW-1:0] d,
                      input string tag);
    exp_t e;
    e.op = op; e.addr = addr; e.data = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic waitReady();
    while (!wrReady) @(negedge clk);
  endtask

  // usedMask bit i set => entry i holds a record; entry 5 uses a one-zero-bit word (R2)
  task automatic boot(input logic [N-1:0] usedMask, input string tag);
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < N; i++)
      mem[i] = usedMask[i] ? ((i == 5) ? 32'hFFFF_FFFE : 32'h1234_0000 + i) : '1;
    repeat (3) @(negedge clk);
    check(wrReady == 1'b0, "R1", "ready in reset", int'(wrReady), 0);
    check(flashCmd == 2'd0, "R1", "command in reset", int'(flashCmd), 0);
    for (int i = 0; i < N; i++) push(2'd1, i, '0, "R1");
    if (&usedMask) push(2'd3, 0, '0, "R5");
    rstN = 1'b1;
    @(negedge clk);
    check(wrReady == 1'b0, "R1", "ready during scan", int'(wrReady), 0);
    waitReady();
    check(expQ.size() == 0, tag, "scan commands left", expQ.size(), 0);
  endtask

  task automatic doWrite(input int expAddr, input logic [DW-1:0] d, input string tag);
    int nxt;
    nxt = (expAddr + 1) % N;
    push(2'd2, expAddr, d, tag);
    if (nxt % SE == 0) push(2'd3, nxt, '0, (nxt == 0) ? "R8" : "R7");
    waitReady();
    wrReq = 1'b1;
    wrData = d;
    @(negedge clk);
    wrReq = 1'b0;
    check(wrReady == 1'b0, "R9", "ready after accept", int'(wrReady), 0);
    @(negedge clk);
    check(!(wrReady && flashBusy), "R9", "ready while busy", int'(wrReady), 0);
    waitReady();
    check(expQ.size() == 0, tag, "commands left before ready", expQ.size(), 0);
  endtask

  initial begin
    // all blank: start at 0, erase sector 1 when reached (R4, R7)
    boot('0, "R4");
    doWrite(0, 32'hA000_0000, "R4");
    doWrite(1, 32'hA000_0001, "R6");
    doWrite(2, 32'hA000_0002, "R6");
    doWrite(3, 32'hA000_0003, "R7");
    // 0..5 used, entry 5 only one bit cleared (R2, R3)
    boot(16'h003F, "R2");
    doWrite(6, 32'hB000_0006, "R2");
    doWrite(7, 32'hB000_0007, "R7");
    // wrapped log: 0..2 and 8..15 used, blank 3..7 (R3)
    boot(16'hFF07, "R3");
    doWrite(3, 32'hC000_0003, "R3");
    // blank 0..3 after used 4..15: entry 0 follows entry 15 (R3)
    boot(16'hFFF0, "R3");
    doWrite(0, 32'hD000_0000, "R3");
    // wrap across the end (R8)
    boot(16'h0FFF, "R3");
    doWrite(12, 32'hE000_000C, "R6");
    doWrite(13, 32'hE000_000D, "R6");
    doWrite(14, 32'hE000_000E, "R6");
    doWrite(15, 32'hE000_000F, "R8");
    doWrite(0, 32'hE000_0010, "R8");
    // no blank entry: erase sector 0 then start at 0 (R5)
    boot('1, "R5");
    doWrite(0, 32'hF000_0000, "R5");
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10", "pending commands at end", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule